// File: doc/BRIEF.md
# ALU Operand Forwarding Unit

This block sits beside the execute stage of a five-stage pipeline and chooses, for each of the two ALU operands, where the value comes from. By default that is the register file. It can also be a result that a later pipeline stage has produced but not yet written back. The block compares the two source register numbers of the instruction now in execute against the destination of the instruction in the memory stage and against the destination of the instruction in writeback. When one of those producers will write the register being read, its result goes to the ALU input in place of the stale register-file value.

If both later stages target the same source, the memory-stage producer is the younger one, so its value wins. A chain of dependent instructions therefore always sees the most recent result. A producer only forwards when its register-write flag is set and its destination is not register zero. An instruction three slots after its producer needs no forwarding, because the register file writes in the first half of the cycle and reads in the second. The block also latches both chosen operands on the clock edge, in the same way as the stage register that feeds the ALU. Load-use stalls and the register file are handled elsewhere.

Top module: `fwd_unit`

## Requirements
- R1: While rst_ni is low, alu_a_q_o and alu_b_q_o are zero.
- R2: If exm_we_i is 1, exm_rd_i is nonzero and exm_rd_i equals ex_rs_i, then fwd_a_o is 2'b10 and alu_a_o equals exm_data_i.
- R3: If the memory-stage producer does not forward to ex_rs_i, and mwb_we_i is 1, mwb_rd_i is nonzero and mwb_rd_i equals ex_rs_i, then fwd_a_o is 2'b01 and alu_a_o equals mwb_data_i.
- R4: If both producers qualify for the same source, the memory-stage producer wins: the select is 2'b10 and the operand is exm_data_i.
- R5: A producer whose write flag is 0 never forwards. With both flags 0, both selects are 2'b00 and the operands equal the register-file values.
- R6: A destination of register zero never forwards, even with its write flag set. The select stays 2'b00 unless the other producer qualifies.
- R7: Operand B follows the same rules as R2 to R6, using ex_rt_i, rf_rt_data_i, fwd_b_o and alu_b_o, and is decided independently of operand A.
- R8: With no qualifying match, the select is 2'b00 and the operand equals its register-file value. This covers a producer three or more slots older.
- R9: On each rising clock edge out of reset, alu_a_q_o and alu_b_q_o take the values alu_a_o and alu_b_o had just before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ex_rs_i | input | REG_AW | First source register of the execute-stage instruction |
| ex_rt_i | input | REG_AW | Second source register of the execute-stage instruction |
| rf_rs_data_i | input | DATA_W | Register-file value read for the first source |
| rf_rt_data_i | input | DATA_W | Register-file value read for the second source |
| exm_rd_i | input | REG_AW | Destination of the memory-stage instruction |
| exm_we_i | input | 1 | Register-write flag of the memory-stage instruction |
| exm_data_i | input | DATA_W | Result held by the memory stage |
| mwb_rd_i | input | REG_AW | Destination of the writeback-stage instruction |
| mwb_we_i | input | 1 | Register-write flag of the writeback-stage instruction |
| mwb_data_i | input | DATA_W | Result held by the writeback stage |
| fwd_a_o | output | 2 | Operand A select: 00 register file, 10 memory stage, 01 writeback |
| fwd_b_o | output | 2 | Operand B select, same encoding |
| alu_a_o | output | DATA_W | Chosen operand A |
| alu_b_o | output | DATA_W | Chosen operand B |
| alu_a_q_o | output | DATA_W | Operand A latched at the clock edge |
| alu_b_q_o | output | DATA_W | Operand B latched at the clock edge |

## Verification
The hardest case to reach is both producers naming the same source with both write flags set, which is the only way to test the priority rule. A close second is a zero destination with its write flag set, which only blocks forwarding if register zero is filtered. Directed items create these cases on each operand separately, and on both at once with different winners. A random phase then draws register numbers from a tiny range, so that matches, double matches and zero destinations occur often.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  typedef enum logic [1:0] {
    SEL_RF  = 2'b00,
    SEL_MWB = 2'b01,
    SEL_EXM = 2'b10
  } fwd_sel_e;

  localparam int unsigned NOPS = 2;
endpackage

// File: rtl/fwd_cmp.sv
module fwd_cmp
  import fwd_pkg::*;
#(
  parameter int unsigned REG_AW = 5
) (
  input  logic [REG_AW-1:0] src_i,
  input  logic [REG_AW-1:0] exm_rd_i,
  input  logic              exm_we_i,
  input  logic [REG_AW-1:0] mwb_rd_i,
  input  logic              mwb_we_i,
  output fwd_sel_e          sel_o
);
  logic exm_hit, mwb_hit;

  assign exm_hit = exm_we_i && (exm_rd_i != '0) && (exm_rd_i == src_i);
  assign mwb_hit = mwb_we_i && (mwb_rd_i != '0) && (mwb_rd_i == src_i);

  // younger producer first
  always_comb begin
    if (exm_hit)      sel_o = SEL_EXM;
    else if (mwb_hit) sel_o = SEL_MWB;
    else              sel_o = SEL_RF;
  end
endmodule

// File: rtl/fwd_mux.sv
module fwd_mux
  import fwd_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  fwd_sel_e          sel_i,
  input  logic [DATA_W-1:0] rf_i,
  input  logic [DATA_W-1:0] exm_i,
  input  logic [DATA_W-1:0] mwb_i,
  output logic [DATA_W-1:0] opnd_o
);
  always_comb begin
    unique case (sel_i)
      SEL_EXM: opnd_o = exm_i;
      SEL_MWB: opnd_o = mwb_i;
      default: opnd_o = rf_i;
    endcase
  end
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
  import fwd_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned REG_AW = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_AW-1:0] ex_rs_i,
  input  logic [REG_AW-1:0] ex_rt_i,
  input  logic [DATA_W-1:0] rf_rs_data_i,
  input  logic [DATA_W-1:0] rf_rt_data_i,
  input  logic [REG_AW-1:0] exm_rd_i,
  input  logic              exm_we_i,
  input  logic [DATA_W-1:0] exm_data_i,
  input  logic [REG_AW-1:0] mwb_rd_i,
  input  logic              mwb_we_i,
  input  logic [DATA_W-1:0] mwb_data_i,
  output logic [1:0]        fwd_a_o,
  output logic [1:0]        fwd_b_o,
  output logic [DATA_W-1:0] alu_a_o,
  output logic [DATA_W-1:0] alu_b_o,
  output logic [DATA_W-1:0] alu_a_q_o,
  output logic [DATA_W-1:0] alu_b_q_o
);
  logic [REG_AW-1:0] src    [NOPS];
  logic [DATA_W-1:0] rf_val [NOPS];
  logic [DATA_W-1:0] opnd   [NOPS];
  logic [DATA_W-1:0] opnd_q [NOPS];
  fwd_sel_e          sel    [NOPS];

  assign src[0]    = ex_rs_i;
  assign src[1]    = ex_rt_i;
  assign rf_val[0] = rf_rs_data_i;
  assign rf_val[1] = rf_rt_data_i;

  for (genvar g = 0; g < NOPS; g++) begin : g_op
    fwd_cmp #(.REG_AW(REG_AW)) u_cmp (
      .src_i    (src[g]),
      .exm_rd_i (exm_rd_i),
      .exm_we_i (exm_we_i),
      .mwb_rd_i (mwb_rd_i),
      .mwb_we_i (mwb_we_i),
      .sel_o    (sel[g])
    );

    fwd_mux #(.DATA_W(DATA_W)) u_mux (
      .sel_i  (sel[g]),
      .rf_i   (rf_val[g]),
      .exm_i  (exm_data_i),
      .mwb_i  (mwb_data_i),
      .opnd_o (opnd[g])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) opnd_q[g] <= '0;
      else         opnd_q[g] <= opnd[g];
    end
  end

  assign fwd_a_o   = sel[0];
  assign fwd_b_o   = sel[1];
  assign alu_a_o   = opnd[0];
  assign alu_b_o   = opnd[1];
  assign alu_a_q_o = opnd_q[0];
  assign alu_b_q_o = opnd_q[1];

  AST_EXM_TO_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exm_we_i && exm_rd_i != '0 && exm_rd_i == ex_rs_i) |-> (fwd_a_o == 2'b10 && alu_a_o == exm_data_i)); // R2
  AST_MWB_TO_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(exm_we_i && exm_rd_i == ex_rs_i) && mwb_we_i && mwb_rd_i != '0 && mwb_rd_i == ex_rs_i)
      |-> (fwd_a_o == 2'b01 && alu_a_o == mwb_data_i)); // R3
  AST_NO_WE_RF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!exm_we_i && !mwb_we_i) |-> (alu_a_o == rf_rs_data_i && alu_b_o == rf_rt_data_i)); // R5
  AST_ZERO_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex_rs_i == '0) |-> (fwd_a_o == 2'b00 && alu_a_o == rf_rs_data_i)); // R6
  AST_EXM_TO_B: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exm_we_i && exm_rd_i != '0 && exm_rd_i == ex_rt_i) |-> (fwd_b_o == 2'b10 && alu_b_o == exm_data_i)); // R7
  AST_SEL_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwd_a_o != 2'b11 && fwd_b_o != 2'b11)); // R4
  AST_OREG_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> ##1 (alu_a_q_o == $past(alu_a_o))); // R9
  AST_OREG_B: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> ##1 (alu_b_q_o == $past(alu_b_o))); // R9
endmodule

// File: tb/sim_fwd_unit.sv
`timescale 1ns/1ps
module sim_fwd_unit;
  localparam int DW = 32;
  localparam int AW = 5;

  typedef struct {
    logic [1:0]    sa, sb;
    logic [DW-1:0] oa, ob;
    string         tag;
  } item_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] rs = '0, rt = '0, exm_rd = '0, mwb_rd = '0;
  logic          exm_we = 1'b0, mwb_we = 1'b0;
  logic [DW-1:0] rf_rs = '0, rf_rt = '0, exm_d = '0, mwb_d = '0;
  logic [1:0]    fa, fb;
  logic [DW-1:0] aa, ab, aqa, aqb;

  int total = 0, bad = 0;
  item_t q[$];
  bit done = 0;

  always #4 clk = ~clk;

  fwd_unit #(.DATA_W(DW), .REG_AW(AW)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .ex_rs_i(rs), .ex_rt_i(rt), .rf_rs_data_i(rf_rs), .rf_rt_data_i(rf_rt),
    .exm_rd_i(exm_rd), .exm_we_i(exm_we), .exm_data_i(exm_d),
    .mwb_rd_i(mwb_rd), .mwb_we_i(mwb_we), .mwb_data_i(mwb_d),
    .fwd_a_o(fa), .fwd_b_o(fb), .alu_a_o(aa), .alu_b_o(ab),
    .alu_a_q_o(aqa), .alu_b_q_o(aqb)
  );

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] ref_sel(input logic [AW-1:0] s);
    if (exm_we && exm_rd != '0 && exm_rd == s) return 2'b10;
    if (mwb_we && mwb_rd != '0 && mwb_rd == s) return 2'b01;
    return 2'b00;
  endfunction

  function automatic logic [DW-1:0] ref_op(input logic [1:0] sel, input logic [DW-1:0] rf);
    return (sel == 2'b10) ? exm_d : (sel == 2'b01) ? mwb_d : rf;
  endfunction

  task automatic drive(input logic [AW-1:0] s, t, er, input bit ew, input logic [AW-1:0] mr, input bit mw, input string tag);
    item_t it;
    @(negedge clk);
    rs = s; rt = t; exm_rd = er; exm_we = ew; mwb_rd = mr; mwb_we = mw;
    rf_rs = $urandom; rf_rt = $urandom; exm_d = $urandom; mwb_d = $urandom;
    it.sa = ref_sel(s); it.sb = ref_sel(t);
    it.oa = ref_op(it.sa, rf_rs); it.ob = ref_op(it.sb, rf_rt);
    it.tag = tag;
    q.push_back(it);
  endtask

  // monitor: after the capturing edge, before the next negedge drive
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        chk(fa == it.sa, {it.tag, " sel A"}, DW'(fa), DW'(it.sa));
        chk(fb == it.sb, {it.tag, " sel B (R7)"}, DW'(fb), DW'(it.sb));
        chk(aa == it.oa, {it.tag, " opnd A"}, aa, it.oa);
        chk(ab == it.ob, {it.tag, " opnd B (R7)"}, ab, it.ob);
        chk(aqa == it.oa, {it.tag, " latched A (R9)"}, aqa, it.oa);
        chk(aqb == it.ob, {it.tag, " latched B (R9)"}, aqb, it.ob);
      end
    end
  end

  initial begin
    #(8 * 200000);
    chk(1'b0, "watchdog", '0, '0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rf_rs = 32'hdead_beef; rf_rt = 32'h1234_5678;
    repeat (3) @(posedge clk);
    #1;
    chk(aqa == '0, "R1 reset A", aqa, '0);
    chk(aqb == '0, "R1 reset B", aqb, '0);
    @(negedge clk); rst_n = 1'b1;

    drive(5'd3, 5'd4, 5'd3, 1, 5'd9, 1, "R2 exm->A");
    drive(5'd3, 5'd4, 5'd9, 1, 5'd3, 1, "R3 mwb->A");
    drive(5'd3, 5'd4, 5'd3, 0, 5'd3, 1, "R3 exm no-we mwb->A");
    drive(5'd7, 5'd7, 5'd7, 1, 5'd7, 1, "R4 both match both ops");
    drive(5'd2, 5'd6, 5'd6, 1, 5'd2, 1, "R4 split winners");
    drive(5'd8, 5'd8, 5'd8, 0, 5'd8, 0, "R5 no write");
    drive(5'd0, 5'd0, 5'd0, 1, 5'd0, 1, "R6 zero dest");
    drive(5'd0, 5'd5, 5'd0, 1, 5'd5, 1, "R6 zero A, mwb->B");
    drive(5'd1, 5'd11, 5'd11, 1, 5'd0, 1, "R7 exm->B only");
    drive(5'd1, 5'd11, 5'd12, 1, 5'd11, 1, "R7 mwb->B only");
    drive(5'd10, 5'd13, 5'd14, 1, 5'd15, 1, "R8 no match");

    for (int i = 0; i < 400; i++) begin
      logic [AW-1:0] v[4];
      foreach (v[k]) v[k] = AW'($urandom_range(0, 3));
      drive(v[0], v[1], v[2], 1'($urandom), v[3], 1'($urandom), "R4/R8 random");
    end
    repeat (3) @(posedge clk);
    #3;
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule